// File: doc/BRIEF.md
# MOESI Snooping Line Coherence Controller

This block keeps the coherence state of every line in a small indexed array that belongs to a write-back cache. Each line is in one of five states: Modified, Owned, Exclusive, Shared or Invalid. The local processor sends it read, write and evict requests. The snoop port carries the read, read-exclusive and upgrade requests that other agents place on the shared bus. The block decides which bus transaction each processor request needs. It answers every snoop with a data-supply enable, a shared-hit response and the line's new state. It raises a writeback request when a dirty line leaves the cache.

Dirty sharing is the central feature. A Modified line that sees a snooped read hands its data straight to the reader and becomes Owned. Memory stays stale until the Owned holder evicts the line, and only then is the line written back. A processor write to an Owned or Shared line must first invalidate the other copies with an upgrade on the bus. A write to a Modified or Exclusive line finishes locally.

Only one processor request is in flight at a time. The processor request uses valid/ready. The bus request and the writeback request are valid/ready-style handshakes closed by `bus_req_ready` and `wb_done`. Once raised, a request stays raised with a stable index until its handshake completes. The snoop port has no back-pressure: a snoop is taken in the cycle it is valid. The bus is assumed never to present a snoop in the same cycle that it grants this block's own request.

Top module: `moesi_line_ctrl`

## Requirements
- R1: State codes on `cpu_done_state` and `snp_new_state` are I=0, S=1, E=2, O=3, M=4. Processor op codes are read=0, write=1, evict=2. Bus and snoop command codes are read=0, read-exclusive=1, upgrade=2.
- R2: After reset every line is Invalid. `bus_req_valid`, `wb_req_valid`, `cpu_done` and `snp_resp_valid` are low, and `cpu_req_ready` is high.
- R3: A read to an Invalid line issues a bus read. In the cycle after the grant, the request completes with state E if `bus_shared` was low at the grant, and with state S if it was high.
- R4: A write to an E or M line completes with state M one cycle after acceptance, with no bus request. A read to any valid line completes with its state unchanged and with no bus request.
- R5: A write to an S or O line issues an upgrade, and a write to an I line issues a read-exclusive. The line becomes M and the request completes in the cycle after the grant.
- R6: A snooped read on an M or O line asserts data supply and shared-hit, and leaves the line in O. No writeback request is raised.
- R7: A snooped read on an E or S line leaves it in S with shared-hit and no supply. A snoop on an Invalid line reports I with neither supply nor shared-hit.
- R8: A snooped read-exclusive moves any valid line to I, and asserts supply only if the line was M or O. A snooped upgrade moves any valid line to I with no supply. Snoop results appear one cycle after the snoop.
- R9: Evicting an M or O line raises `wb_req_valid` with the line index and holds it until `wb_done`. In the cycle after `wb_done`, the request completes with state I.
- R10: Evicting an E or S line completes with state I one cycle after acceptance, with no writeback request.
- R11: A pending upgrade whose line a snoop has invalidated is promoted to read-exclusive before it is granted.
- R12: `cpu_req_ready` is low while a request is outstanding. It is also low when a valid snoop targets the same index as the presented request.
- R13: `bus_req_valid` with `bus_req_idx` stays stable until `bus_req_ready`. `wb_req_valid` with `wb_req_idx` stays stable until `wb_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Processor request accepted when high with valid |
| cpu_req_op | input | 2 | Processor operation code |
| cpu_req_idx | input | IW | Line index of the processor request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_done_state | output | 3 | Line state after the completed request |
| bus_req_valid | output | 1 | Bus transaction request |
| bus_req_ready | input | 1 | Bus grant |
| bus_req_cmd | output | 2 | Bus command |
| bus_req_idx | output | IW | Line index of the bus request |
| bus_shared | input | 1 | Another cache holds the line, sampled at the grant |
| snp_valid | input | 1 | Snooped transaction valid |
| snp_cmd | input | 2 | Snooped command |
| snp_idx | input | IW | Snooped line index |
| snp_resp_valid | output | 1 | Snoop result valid |
| snp_supply | output | 1 | This cache supplies the data |
| snp_shared | output | 1 | Shared-hit response |
| snp_new_state | output | 3 | Line state after the snoop |
| wb_req_valid | output | 1 | Writeback request |
| wb_req_idx | output | IW | Line index to write back |
| wb_done | input | 1 | Writeback completed |

## Verification
The bench builds the block with four lines, so a two-bit index. Every line can be walked through its own state sequence, and the top index is covered on the same path as the others. The small array makes one case easy to reach: a processor request and a snoop aimed at the same line in the same cycle. It also brings within reach a snoop that lands on the very line a pending upgrade is waiting for. That is where the stall on a colliding snoop and the promotion of an upgrade to read-exclusive can be seen.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

  typedef enum logic [2:0] {
    LS_I = 3'd0,
    LS_S = 3'd1,
    LS_E = 3'd2,
    LS_O = 3'd3,
    LS_M = 3'd4
  } line_state_t;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_EVICT = 2'd2
  } cpu_op_t;

  typedef enum logic [1:0] {
    BC_RD   = 2'd0,
    BC_RDX  = 2'd1,
    BC_UPGR = 2'd2
  } bus_cmd_t;

  typedef struct packed {
    line_state_t nxt;
    logic        supply;
    logic        shared;
  } snoop_verdict_t;

  function automatic logic is_dirty(line_state_t s);
    return (s == LS_M) || (s == LS_O);
  endfunction

  // Reaction of one line to a transaction seen on the bus.
  function automatic snoop_verdict_t snoop_verdict(line_state_t cur, bus_cmd_t cmd);
    snoop_verdict_t v;
    v.nxt    = cur;
    v.supply = 1'b0;
    v.shared = 1'b0;
    if (cur != LS_I) begin
      case (cmd)
        BC_RD: begin
          v.shared = 1'b1;
          if (is_dirty(cur)) begin
            v.nxt    = LS_O;
            v.supply = 1'b1;
          end else begin
            v.nxt = LS_S;
          end
        end
        BC_RDX: begin
          v.nxt    = LS_I;
          v.supply = is_dirty(cur);
        end
        BC_UPGR: v.nxt = LS_I;
        default: v.nxt = cur;
      endcase
    end
    return v;
  endfunction

endpackage

// File: rtl/moesi_state_array.sv
module moesi_state_array
  import moesi_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int IW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] a_idx,
  output line_state_t   a_state,
  input  logic [IW-1:0] b_idx,
  output line_state_t   b_state,
  input  logic          cpu_we,
  input  logic [IW-1:0] cpu_widx,
  input  line_state_t   cpu_wstate,
  input  logic          snp_we,
  input  logic [IW-1:0] snp_widx,
  input  line_state_t   snp_wstate
);

  line_state_t st_q [NUM_LINES];

  // The processor-side write is applied last, so it wins a same-index clash.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LINES; i++) st_q[i] <= LS_I;
    end else begin
      if (snp_we) st_q[snp_widx] <= snp_wstate;
      if (cpu_we) st_q[cpu_widx] <= cpu_wstate;
    end
  end

  assign a_state = st_q[a_idx];
  assign b_state = st_q[b_idx];

endmodule

// File: rtl/moesi_snoop_unit.sv
module moesi_snoop_unit
  import moesi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        snp_valid,
  input  bus_cmd_t    snp_cmd,
  input  line_state_t cur_state,
  output logic        upd_we,
  output line_state_t upd_state,
  output logic        resp_valid,
  output logic        resp_supply,
  output logic        resp_shared,
  output line_state_t resp_state
);

  snoop_verdict_t v;

  assign v         = snoop_verdict(cur_state, snp_cmd);
  assign upd_we    = snp_valid && (v.nxt != cur_state);
  assign upd_state = v.nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_supply <= 1'b0;
      resp_shared <= 1'b0;
      resp_state  <= LS_I;
    end else begin
      resp_valid  <= snp_valid;
      resp_supply <= snp_valid && v.supply;
      resp_shared <= snp_valid && v.shared;
      resp_state  <= snp_valid ? v.nxt : LS_I;
    end
  end

endmodule

// File: rtl/moesi_cpu_fsm.sv
module moesi_cpu_fsm
  import moesi_pkg::*;
#(
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  cpu_op_t       req_op,
  input  logic [IW-1:0] req_idx,
  input  logic          snp_valid,
  input  logic [IW-1:0] snp_idx,
  output logic [IW-1:0] look_idx,
  input  line_state_t   look_state,
  output logic          bus_valid,
  input  logic          bus_ready,
  output bus_cmd_t      bus_cmd,
  output logic [IW-1:0] bus_idx,
  input  logic          bus_shared,
  output logic          wb_valid,
  output logic [IW-1:0] wb_idx,
  input  logic          wb_done,
  output logic          line_we,
  output logic [IW-1:0] line_widx,
  output line_state_t   line_wstate,
  output logic          done,
  output line_state_t   done_state
);

  typedef enum logic [1:0] {F_IDLE, F_BUS, F_WB} fsm_t;

  fsm_t          st_q, st_d;
  cpu_op_t       op_q;
  logic [IW-1:0] idx_q;
  logic          accept;
  logic          done_d;
  line_state_t   done_state_d;

  assign look_idx  = (st_q == F_IDLE) ? req_idx : idx_q;
  assign req_ready = (st_q == F_IDLE) && !(snp_valid && (snp_idx == req_idx));
  assign accept    = req_valid && req_ready;

  // The bus command follows the live line state, so a snoop that kills the
  // local copy while the request waits turns an upgrade into a read-exclusive.
  always_comb begin
    bus_valid = (st_q == F_BUS);
    bus_idx   = idx_q;
    if (op_q == OP_WRITE)
      bus_cmd = ((look_state == LS_S) || (look_state == LS_O)) ? BC_UPGR : BC_RDX;
    else
      bus_cmd = BC_RD;
    wb_valid = (st_q == F_WB);
    wb_idx   = idx_q;
  end

  always_comb begin
    st_d         = st_q;
    line_we      = 1'b0;
    line_widx    = look_idx;
    line_wstate  = look_state;
    done_d       = 1'b0;
    done_state_d = look_state;
    case (st_q)
      F_IDLE: begin
        if (accept) begin
          case (req_op)
            OP_READ: begin
              if (look_state == LS_I) st_d = F_BUS;
              else done_d = 1'b1;
            end
            OP_WRITE: begin
              if ((look_state == LS_M) || (look_state == LS_E)) begin
                line_we      = 1'b1;
                line_wstate  = LS_M;
                done_d       = 1'b1;
                done_state_d = LS_M;
              end else begin
                st_d = F_BUS;
              end
            end
            OP_EVICT: begin
              if (is_dirty(look_state)) begin
                st_d = F_WB;
              end else begin
                line_we      = 1'b1;
                line_wstate  = LS_I;
                done_d       = 1'b1;
                done_state_d = LS_I;
              end
            end
            default: done_d = 1'b1;
          endcase
        end
      end
      F_BUS: begin
        if (bus_ready) begin
          line_we = 1'b1;
          if (op_q == OP_READ) line_wstate = bus_shared ? LS_S : LS_E;
          else                 line_wstate = LS_M;
          done_d       = 1'b1;
          done_state_d = line_wstate;
          st_d         = F_IDLE;
        end
      end
      F_WB: begin
        if (wb_done) begin
          line_we      = 1'b1;
          line_wstate  = LS_I;
          done_d       = 1'b1;
          done_state_d = LS_I;
          st_d         = F_IDLE;
        end
      end
      default: st_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= F_IDLE;
      op_q       <= OP_READ;
      idx_q      <= '0;
      done       <= 1'b0;
      done_state <= LS_I;
    end else begin
      st_q       <= st_d;
      done       <= done_d;
      done_state <= done_state_d;
      if (accept) begin
        op_q  <= req_op;
        idx_q <= req_idx;
      end
    end
  end

endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
  import moesi_pkg::*;
#(
  parameter  int NUM_LINES = 16,
  localparam int IW        = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req_valid,
  output logic          cpu_req_ready,
  input  logic [1:0]    cpu_req_op,
  input  logic [IW-1:0] cpu_req_idx,
  output logic          cpu_done,
  output logic [2:0]    cpu_done_state,
  output logic          bus_req_valid,
  input  logic          bus_req_ready,
  output logic [1:0]    bus_req_cmd,
  output logic [IW-1:0] bus_req_idx,
  input  logic          bus_shared,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [IW-1:0] snp_idx,
  output logic          snp_resp_valid,
  output logic          snp_supply,
  output logic          snp_shared,
  output logic [2:0]    snp_new_state,
  output logic          wb_req_valid,
  output logic [IW-1:0] wb_req_idx,
  input  logic          wb_done
);

  logic [IW-1:0] look_idx;
  line_state_t   look_state;
  line_state_t   snp_cur_state;
  logic          cpu_we;
  logic [IW-1:0] cpu_widx;
  line_state_t   cpu_wstate;
  logic          snp_we;
  line_state_t   snp_wstate;
  bus_cmd_t      bus_cmd_e;
  line_state_t   done_state_e;
  line_state_t   snp_state_e;

  moesi_state_array #(
    .NUM_LINES (NUM_LINES),
    .IW        (IW)
  ) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_idx      (look_idx),
    .a_state    (look_state),
    .b_idx      (snp_idx),
    .b_state    (snp_cur_state),
    .cpu_we     (cpu_we),
    .cpu_widx   (cpu_widx),
    .cpu_wstate (cpu_wstate),
    .snp_we     (snp_we),
    .snp_widx   (snp_idx),
    .snp_wstate (snp_wstate)
  );

  moesi_snoop_unit u_snoop (
    .clk         (clk),
    .rst_n       (rst_n),
    .snp_valid   (snp_valid),
    .snp_cmd     (bus_cmd_t'(snp_cmd)),
    .cur_state   (snp_cur_state),
    .upd_we      (snp_we),
    .upd_state   (snp_wstate),
    .resp_valid  (snp_resp_valid),
    .resp_supply (snp_supply),
    .resp_shared (snp_shared),
    .resp_state  (snp_state_e)
  );

  moesi_cpu_fsm #(
    .IW (IW)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (cpu_req_valid),
    .req_ready   (cpu_req_ready),
    .req_op      (cpu_op_t'(cpu_req_op)),
    .req_idx     (cpu_req_idx),
    .snp_valid   (snp_valid),
    .snp_idx     (snp_idx),
    .look_idx    (look_idx),
    .look_state  (look_state),
    .bus_valid   (bus_req_valid),
    .bus_ready   (bus_req_ready),
    .bus_cmd     (bus_cmd_e),
    .bus_idx     (bus_req_idx),
    .bus_shared  (bus_shared),
    .wb_valid    (wb_req_valid),
    .wb_idx      (wb_req_idx),
    .wb_done     (wb_done),
    .line_we     (cpu_we),
    .line_widx   (cpu_widx),
    .line_wstate (cpu_wstate),
    .done        (cpu_done),
    .done_state  (done_state_e)
  );

  assign bus_req_cmd    = bus_cmd_e;
  assign cpu_done_state = done_state_e;
  assign snp_new_state  = snp_state_e;

endmodule

// File: rtl/moesi_line_ctrl_chk.sv
module moesi_line_ctrl_chk #(
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req_ready,
  input logic          cpu_done,
  input logic [2:0]    cpu_done_state,
  input logic          bus_req_valid,
  input logic          bus_req_ready,
  input logic [IW-1:0] bus_req_idx,
  input logic          snp_resp_valid,
  input logic          snp_supply,
  input logic          snp_shared,
  input logic [2:0]    snp_new_state,
  input logic          wb_req_valid,
  input logic [IW-1:0] wb_req_idx,
  input logic          wb_done
);

  assert_bus_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_req_idx));

  assert_wb_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req_valid && !wb_done |=> wb_req_valid && $stable(wb_req_idx));

  assert_single_outstanding_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> !wb_req_valid && !cpu_req_ready);

  assert_done_after_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && bus_req_ready |=> cpu_done);

  assert_wb_ends_invalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req_valid && wb_done |=> cpu_done && (cpu_done_state == 3'd0));

  assert_supplier_leaves_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    snp_resp_valid && snp_supply |-> (snp_new_state == 3'd3) || (snp_new_state == 3'd0));

  assert_shared_hit_keeps_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_resp_valid && snp_shared |-> snp_new_state != 3'd0);

endmodule

bind moesi_line_ctrl moesi_line_ctrl_chk #(.IW(IW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cpu_req_ready  (cpu_req_ready),
  .cpu_done       (cpu_done),
  .cpu_done_state (cpu_done_state),
  .bus_req_valid  (bus_req_valid),
  .bus_req_ready  (bus_req_ready),
  .bus_req_idx    (bus_req_idx),
  .snp_resp_valid (snp_resp_valid),
  .snp_supply     (snp_supply),
  .snp_shared     (snp_shared),
  .snp_new_state  (snp_new_state),
  .wb_req_valid   (wb_req_valid),
  .wb_req_idx     (wb_req_idx),
  .wb_done        (wb_done)
);

// File: tb/moesi_line_ctrl_tb.sv
`timescale 1ns/1ps
module moesi_line_ctrl_tb;

  localparam int NL = 4;
  localparam int IW = 2;
  localparam int ST_I = 0, ST_S = 1, ST_E = 2, ST_O = 3, ST_M = 4;
  localparam int OPR = 0, OPW = 1, OPE = 2;
  localparam int CRD = 0, CRDX = 1, CUPG = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req_valid = 1'b0;
  logic          cpu_req_ready;
  logic [1:0]    cpu_req_op = '0;
  logic [IW-1:0] cpu_req_idx = '0;
  logic          cpu_done;
  logic [2:0]    cpu_done_state;
  logic          bus_req_valid;
  logic          bus_req_ready = 1'b0;
  logic [1:0]    bus_req_cmd;
  logic [IW-1:0] bus_req_idx;
  logic          bus_shared = 1'b0;
  logic          snp_valid = 1'b0;
  logic [1:0]    snp_cmd = '0;
  logic [IW-1:0] snp_idx = '0;
  logic          snp_resp_valid;
  logic          snp_supply;
  logic          snp_shared;
  logic [2:0]    snp_new_state;
  logic          wb_req_valid;
  logic [IW-1:0] wb_req_idx;
  logic          wb_done = 1'b0;

  always #2.5 clk = ~clk;

  moesi_line_ctrl #(.NUM_LINES(NL)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_op(cpu_req_op), .cpu_req_idx(cpu_req_idx),
    .cpu_done(cpu_done), .cpu_done_state(cpu_done_state),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_cmd(bus_req_cmd), .bus_req_idx(bus_req_idx), .bus_shared(bus_shared),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_idx(snp_idx),
    .snp_resp_valid(snp_resp_valid), .snp_supply(snp_supply),
    .snp_shared(snp_shared), .snp_new_state(snp_new_state),
    .wb_req_valid(wb_req_valid), .wb_req_idx(wb_req_idx), .wb_done(wb_done)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    finished = 0;
  bit    bus_seen = 0;
  bit    wb_seen = 0;
  int    cpu_q[$];
  string cpu_tag_q[$];
  int    snp_q[$];
  string snp_tag_q[$];

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: pops expectations as results appear.
  always @(negedge clk) begin
    int    e;
    string t;
    if (bus_req_valid) bus_seen = 1;
    if (wb_req_valid)  wb_seen = 1;
    if (rst_n && cpu_done) begin
      if (cpu_q.size() == 0) chk("R4 unexpected completion", 1, 0);
      else begin
        e = cpu_q.pop_front();
        t = cpu_tag_q.pop_front();
        chk(t, int'(cpu_done_state), e);
      end
    end
    if (rst_n && snp_resp_valid) begin
      if (snp_q.size() == 0) chk("R8 unexpected snoop result", 1, 0);
      else begin
        e = snp_q.pop_front();
        t = snp_tag_q.pop_front();
        chk(t, int'(snp_new_state) * 4 + int'(snp_supply) * 2 + int'(snp_shared), e);
      end
    end
  end

  task automatic cpu_issue(input int op, input int idx, input int exp, input string tag);
    @(negedge clk);
    cpu_q.push_back(exp);
    cpu_tag_q.push_back(tag);
    bus_seen = 0;
    wb_seen = 0;
    cpu_req_valid = 1'b1;
    cpu_req_op = op[1:0];
    cpu_req_idx = idx[IW-1:0];
    #1;
    while (!cpu_req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
  endtask

  task automatic bus_serve(input int cmd, input int idx, input bit sh, input string tag);
    int guard = 0;
    while (!bus_req_valid && guard < 50) begin
      @(negedge clk);
      guard++;
    end
    chk({tag, " bus command"}, int'(bus_req_cmd), cmd);
    chk({tag, " bus index"}, int'(bus_req_idx), idx);
    bus_shared = sh;
    bus_req_ready = 1'b1;
    @(negedge clk);
    bus_req_ready = 1'b0;
    bus_shared = 1'b0;
  endtask

  task automatic wb_serve(input int idx, input int hold, input string tag);
    int guard = 0;
    while (!wb_req_valid && guard < 50) begin
      @(negedge clk);
      guard++;
    end
    chk({tag, " writeback index"}, int'(wb_req_idx), idx);
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk("R13 writeback held", int'(wb_req_valid), 1);
      chk("R13 writeback index stable", int'(wb_req_idx), idx);
    end
    wb_done = 1'b1;
    @(negedge clk);
    wb_done = 1'b0;
  endtask

  task automatic snoop(input int cmd, input int idx, input int st, input int sup,
                       input int sh, input string tag);
    @(negedge clk);
    snp_q.push_back(st * 4 + sup * 2 + sh);
    snp_tag_q.push_back(tag);
    snp_valid = 1'b1;
    snp_cmd = cmd[1:0];
    snp_idx = idx[IW-1:0];
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    repeat (3) @(negedge clk);
    chk({tag, " all results seen"}, cpu_q.size() + snp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 no bus request in reset", int'(bus_req_valid), 0);
    chk("R2 no writeback in reset", int'(wb_req_valid), 0);
    chk("R2 no completion in reset", int'(cpu_done), 0);
    chk("R2 no snoop result in reset", int'(snp_resp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 ready after reset", int'(cpu_req_ready), 1);

    // Read miss, no other sharer -> E
    cpu_issue(OPR, 0, ST_E, "R1 R3 fill exclusive");
    bus_serve(CRD, 0, 1'b0, "R3");
    drain("R3");
    // Write hit on E -> M silently
    cpu_issue(OPW, 0, ST_M, "R4 write hit on E");
    drain("R4");
    chk("R4 write hit used no bus", int'(bus_seen), 0);
    cpu_issue(OPR, 0, ST_M, "R4 read hit on M");
    drain("R4");
    chk("R4 read hit used no bus", int'(bus_seen), 0);
    // Dirty sharing
    snoop(CRD, 0, ST_O, 1, 1, "R6 snooped read on M");
    snoop(CRD, 0, ST_O, 1, 1, "R6 snooped read on O");
    chk("R6 no writeback on dirty share", int'(wb_seen), 0);
    cpu_issue(OPW, 0, ST_M, "R5 write on O");
    bus_serve(CUPG, 0, 1'b0, "R5 O upgrade");
    drain("R5");
    snoop(CRDX, 0, ST_I, 1, 0, "R8 read-exclusive on M");
    // Shared fill and clean snoops
    cpu_issue(OPR, 1, ST_S, "R3 fill shared");
    bus_serve(CRD, 1, 1'b1, "R3");
    drain("R3");
    snoop(CRD, 1, ST_S, 0, 1, "R7 snooped read on S");
    snoop(CRD, 2, ST_I, 0, 0, "R7 snoop on I");
    cpu_issue(OPW, 1, ST_M, "R5 write on S");
    bus_serve(CUPG, 1, 1'b0, "R5 S upgrade");
    drain("R5");
    cpu_issue(OPW, 2, ST_M, "R5 write miss");
    bus_serve(CRDX, 2, 1'b0, "R5 I read-exclusive");
    drain("R5");
    // Dirty eviction
    cpu_issue(OPE, 2, ST_I, "R9 evict M");
    wb_serve(2, 3, "R9");
    drain("R9");
    chk("R9 eviction used no bus", int'(bus_seen), 0);
    snoop(CRD, 2, ST_I, 0, 0, "R9 evicted line invalid");
    // Top index, E -> S by snoop, silent eviction
    cpu_issue(OPR, 3, ST_E, "R3 fill top index");
    bus_serve(CRD, 3, 1'b0, "R3");
    drain("R3");
    snoop(CRD, 3, ST_S, 0, 1, "R7 snooped read on E");
    cpu_issue(OPE, 3, ST_I, "R10 evict S");
    drain("R10");
    chk("R10 no writeback for clean", int'(wb_seen), 0);
    snoop(CRDX, 3, ST_I, 0, 0, "R10 line invalid after evict");
    // Upgrade snoop
    snoop(CRD, 1, ST_O, 1, 1, "R6 M to O");
    snoop(CUPG, 1, ST_I, 0, 0, "R8 upgrade snooped on O");
    // Promotion of a pending upgrade
    cpu_issue(OPR, 3, ST_S, "R3 fill shared top");
    bus_serve(CRD, 3, 1'b1, "R3");
    drain("R3");
    cpu_issue(OPW, 3, ST_M, "R11 promoted write completes M");
    chk("R5 upgrade pending for S", int'(bus_req_cmd), CUPG);
    chk("R12 ready low while busy", int'(cpu_req_ready), 0);
    snoop(CRDX, 3, ST_I, 0, 0, "R8 R11 read-exclusive kills S");
    chk("R13 bus request held", int'(bus_req_valid), 1);
    chk("R11 promoted to read-exclusive", int'(bus_req_cmd), CRDX);
    bus_serve(CRDX, 3, 1'b0, "R11");
    drain("R11");
    // Collision between processor and snoop on the same line
    @(negedge clk);
    cpu_q.push_back(ST_O);
    cpu_tag_q.push_back("R12 read after colliding snoop");
    snp_q.push_back(ST_O * 4 + 2 + 1);
    snp_tag_q.push_back("R6 colliding snoop M to O");
    cpu_req_valid = 1'b1;
    cpu_req_op = OPR[1:0];
    cpu_req_idx = 2'd3;
    snp_valid = 1'b1;
    snp_cmd = CRD[1:0];
    snp_idx = 2'd3;
    #1;
    chk("R12 ready low on collision", int'(cpu_req_ready), 0);
    @(negedge clk);
    snp_valid = 1'b0;
    #1;
    chk("R12 ready back after collision", int'(cpu_req_ready), 1);
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    drain("R12");
    // Owned eviction writes back
    cpu_issue(OPE, 3, ST_I, "R9 evict O");
    wb_serve(3, 1, "R9");
    drain("R9");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20000 * 5.0);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule